// File: doc/BRIEF.md
# Six-Channel Down-Counting Timer Unit

This block holds six independent 32-bit down-counters, arranged as three identical groups of two, behind a simple 32-bit register port. Each counter runs on the block clock. While it is running, it loses one per clock. When it reaches zero, it reloads from its own reload register on the next clock and records an event. The six event bits share one capture register, which is cleared by writing ones. They also share one enable mask. The single interrupt output is high while any enabled channel has a pending event.

A clock-control register at the core level can halt the whole unit. While the unit is halted, every counter holds its value and writes to the per-timer registers are dropped. Reads, interrupt register accesses and clock-control writes keep working. A read-only identification register returns a fixed magic value.

Each channel is a two-state machine. In `CH_IDLE` the counter holds. In `CH_COUNT` it decrements and wraps. A run-register write with the start bit set moves the channel from `CH_IDLE` to `CH_COUNT`. A run-register write with the start bit clear moves it back to `CH_IDLE`. The core is a second two-state machine. `CORE_ACTIVE` passes to `CORE_HALTED` on a clock-control write with bit 0 set. `CORE_HALTED` returns to `CORE_ACTIVE` on a clock-control write with bit 0 clear.

Top module: `sixch_timer_unit`

## Requirements
- R1: After reset, every mapped register reads 0 except the identification register, and `irq_out` is low.
- R2: Offset 0x08 always reads 0x0000_5900 (magic 0x59 in bits 15:8). Writes to it have no effect.
- R3: Channel n has its base at 0x10 + 0x20*(n/2) + 4*(n%2). Its control register is at base+0x00, run at base+0x08, reload at base+0x10 and count at base+0x18. Reads of any unmapped byte offset, including 0x04, 0x0C and 0xF8, return 0.
- R4: The control register keeps only bits 2, 6, 7, 8 and 10 (mask 0x5C4). Its other bits read 0, and its value does not affect counting.
- R5: A run-register write sets the running state from data bit 0. If data bit 2 is 1, the count is loaded from the reload register in that same cycle. In the cycle of a run write, the count does not decrement and no event is raised. The run register reads back only the running state, in bit 0.
- R6: A running channel's count drops by exactly one per clock. Writes to the count register are ignored.
- R7: When a running channel's count is 0, the next clock loads the reload value and sets that channel's capture bit. With a reload value of 0, this happens on every clock.
- R8: The capture register is at 0xFC and the enable register at 0xF4, with bit n belonging to channel n. Writing 1 to a capture bit clears it. A capture bit that is set and cleared in the same cycle ends up set.
- R9: `irq_out` is the OR over channels of (capture AND enable). Capture bits are set whether or not the channel is enabled.
- R10: The clock-control register at 0x00 keeps bits 0, 4 and 8. While bit 0 is 1, all counts hold and timer register writes are dropped. Enable and capture writes still act while bit 0 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Pending enabled event on any channel |

## Verification
The bench targets the cycle on which a zero count wraps. A design that decrements through zero to 0xFFFF_FFFF, or that sets the capture bit one clock late, misses the reference count and `irq_out` on that exact cycle. Setting the reload value to 0 produces an event on every clock, and the bench writes a clear on one of those cycles. A design that lets the clear win loses an event and shows a low `irq_out`. The bench also writes timer registers while the core is halted, and ends with reads of unmapped offsets and of a wide reload value. A design that ignores the halt lets the counts drift or accepts the writes. A decoder with a wrong group stride or pair offset returns data on the wrong offset.

// File: rtl/sixch_timer_pkg.sv
package sixch_timer_pkg;

    localparam int DATA_W       = 32;
    localparam int OFS_CLC      = 'h00;
    localparam int OFS_ID       = 'h08;
    localparam int OFS_IEN      = 'h F4;
    localparam int OFS_CAP      = 'hFC;
    localparam int GRP_BASE     = 'h10;
    localparam int GRP_STRIDE   = 'h20;
    localparam int PAIR_STEP    = 'h04;
    localparam int REG_CTRL     = 'h00;
    localparam int REG_RUN      = 'h08;
    localparam int REG_RLD      = 'h10;
    localparam int REG_CNT      = 'h18;

    localparam logic [DATA_W-1:0] ID_VALUE  = 32'h0000_5900;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_05C4;

    localparam int CLC_HALT_BIT  = 0;
    localparam int CLC_SUSP_BIT  = 4;
    localparam int CLC_RMODE_BIT = 8;
    localparam int RUN_START_BIT = 0;
    localparam int RUN_LOAD_BIT  = 2;

    typedef enum logic {
        CH_IDLE  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_e;

    typedef enum logic {
        CORE_ACTIVE = 1'b0,
        CORE_HALTED = 1'b1
    } core_state_e;

    function automatic int chan_base(input int ch);
        return GRP_BASE + GRP_STRIDE * (ch / 2) + PAIR_STEP * (ch % 2);
    endfunction

endpackage

// File: rtl/sixch_timer_chan.sv
module sixch_timer_chan
    import sixch_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              wr_ctrl,
    input  logic              wr_run,
    input  logic              wr_rld,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              running,
    output logic [CNT_W-1:0]  rld_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              wrap
);

    ch_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_nx;
    end

    // next state: only a run write moves the channel
    always_comb begin
        state_nx = state_q;
        if (wr_run) begin
            state_nx = wdata[RUN_START_BIT] ? CH_COUNT : CH_IDLE;
        end
    end

    // outputs
    always_comb begin
        running = 1'b0;
        wrap    = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                running = 1'b0;
                wrap    = 1'b0;
            end
            CH_COUNT: begin
                running = 1'b1;
                wrap    = !freeze && !wr_run && (cnt_q == '0);
            end
            default: begin
                running = 1'b0;
                wrap    = 1'b0;
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rld_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
            if (wr_rld)  rld_q  <= wdata[CNT_W-1:0];
            if (wr_run) begin
                if (wdata[RUN_LOAD_BIT]) cnt_q <= rld_q;
            end else if (running && !freeze) begin
                cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - 1'b1;
            end
        end
    end

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !wr_run) |=> $stable(cnt_q)); // R10
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && !freeze && !wr_run && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
    AST_WRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == $past(rld_q))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !wr_run) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/sixch_timer_irq.sv
module sixch_timer_irq #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] wrap,
    input  logic              wr_ien,
    input  logic              wr_cap,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] cap_q,
    output logic [NUM_CH-1:0] ien_q,
    output logic              irq
);

    logic [NUM_CH-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_cap ? wbits : '0;
        irq      = |(cap_q & ien_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
            ien_q <= '0;
        end else begin
            cap_q <= (cap_q & ~clr_mask) | wrap;
            if (wr_ien) ien_q <= wbits;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((cap_q & $past(wrap)) == $past(wrap))); // R8
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cap && |(wbits & ~wrap))
        |=> ((cap_q & $past(wbits & ~wrap)) == '0)); // R8
    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cap) |=> ((cap_q & $past(cap_q)) == $past(cap_q))); // R9

endmodule

// File: rtl/sixch_timer_regif.sv
module sixch_timer_regif
    import sixch_timer_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic                           freeze,
    output logic [NUM_CH-1:0]              wr_ctrl,
    output logic [NUM_CH-1:0]              wr_run,
    output logic [NUM_CH-1:0]              wr_rld,
    output logic                           wr_ien,
    output logic                           wr_cap,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_ctrl,
    input  logic [NUM_CH-1:0]              ch_run,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   ch_rld,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt,
    input  logic [NUM_CH-1:0]              cap_q,
    input  logic [NUM_CH-1:0]              ien_q
);

    core_state_e core_q, core_nx;
    logic        susp_q, rmode_q;
    logic        hit_clc, hit_id, hit_ien, hit_cap;
    logic [NUM_CH-1:0] hit_ctrl, hit_run, hit_rld, hit_cnt;

    assign hit_clc = (addr == ADDR_W'(OFS_CLC));
    assign hit_id  = (addr == ADDR_W'(OFS_ID));
    assign hit_ien = (addr == ADDR_W'(OFS_IEN));
    assign hit_cap = (addr == ADDR_W'(OFS_CAP));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam int BASE = chan_base(i);
        assign hit_ctrl[i] = (addr == ADDR_W'(BASE + REG_CTRL));
        assign hit_run[i]  = (addr == ADDR_W'(BASE + REG_RUN));
        assign hit_rld[i]  = (addr == ADDR_W'(BASE + REG_RLD));
        assign hit_cnt[i]  = (addr == ADDR_W'(BASE + REG_CNT));
    end

    // core state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q  <= CORE_ACTIVE;
            susp_q  <= 1'b0;
            rmode_q <= 1'b0;
        end else begin
            core_q <= core_nx;
            if (wr_en && hit_clc) begin
                susp_q  <= wdata[CLC_SUSP_BIT];
                rmode_q <= wdata[CLC_RMODE_BIT];
            end
        end
    end

    // core next state
    always_comb begin
        core_nx = core_q;
        unique case (core_q)
            CORE_ACTIVE: if (wr_en && hit_clc && wdata[CLC_HALT_BIT])  core_nx = CORE_HALTED;
            CORE_HALTED: if (wr_en && hit_clc && !wdata[CLC_HALT_BIT]) core_nx = CORE_ACTIVE;
            default:     core_nx = CORE_ACTIVE;
        endcase
    end

    // outputs: freeze and write strobes
    always_comb begin
        freeze  = (core_q == CORE_HALTED);
        wr_ctrl = (wr_en && !freeze) ? hit_ctrl : '0;
        wr_run  = (wr_en && !freeze) ? hit_run  : '0;
        wr_rld  = (wr_en && !freeze) ? hit_rld  : '0;
        wr_ien  = wr_en && hit_ien;
        wr_cap  = wr_en && hit_cap;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (hit_clc) begin
            rdata[CLC_HALT_BIT]  = freeze;
            rdata[CLC_SUSP_BIT]  = susp_q;
            rdata[CLC_RMODE_BIT] = rmode_q;
        end else if (hit_id) begin
            rdata = ID_VALUE;
        end else if (hit_ien) begin
            rdata = DATA_W'(ien_q);
        end else if (hit_cap) begin
            rdata = DATA_W'(cap_q);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (hit_ctrl[i]) rdata = ch_ctrl[i];
                if (hit_run[i])  rdata = DATA_W'(ch_run[i]);
                if (hit_rld[i])  rdata = DATA_W'(ch_rld[i]);
                if (hit_cnt[i])  rdata = DATA_W'(ch_cnt[i]);
            end
        end
    end

    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        hit_id |-> (rdata == ID_VALUE)); // R2
    AST_HALT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_clc && wdata[CLC_HALT_BIT]) |=> (wr_run == '0 && wr_rld == '0)); // R10
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_clc, hit_id, hit_ien, hit_cap, hit_ctrl, hit_run, hit_rld, hit_cnt})); // R3

endmodule

// File: rtl/sixch_timer_unit.sv
module sixch_timer_unit
    import sixch_timer_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);

    logic                          freeze;
    logic [NUM_CH-1:0]             wr_ctrl, wr_run, wr_rld;
    logic                          wr_ien, wr_cap;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0]             ch_run;
    logic [NUM_CH-1:0][CNT_W-1:0]  ch_rld, ch_cnt;
    logic [NUM_CH-1:0]             ch_wrap, cap_q, ien_q;

    sixch_timer_regif #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) i_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .freeze  (freeze),
        .wr_ctrl (wr_ctrl),
        .wr_run  (wr_run),
        .wr_rld  (wr_rld),
        .wr_ien  (wr_ien),
        .wr_cap  (wr_cap),
        .ch_ctrl (ch_ctrl),
        .ch_run  (ch_run),
        .ch_rld  (ch_rld),
        .ch_cnt  (ch_cnt),
        .cap_q   (cap_q),
        .ien_q   (ien_q)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        sixch_timer_chan #(
            .CNT_W (CNT_W)
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .freeze  (freeze),
            .wr_ctrl (wr_ctrl[i]),
            .wr_run  (wr_run[i]),
            .wr_rld  (wr_rld[i]),
            .wdata   (reg_wdata),
            .ctrl_q  (ch_ctrl[i]),
            .running (ch_run[i]),
            .rld_q   (ch_rld[i]),
            .cnt_q   (ch_cnt[i]),
            .wrap    (ch_wrap[i])
        );
    end

    sixch_timer_irq #(
        .NUM_CH (NUM_CH)
    ) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (ch_wrap),
        .wr_ien (wr_ien),
        .wr_cap (wr_cap),
        .wbits  (reg_wdata[NUM_CH-1:0]),
        .cap_q  (cap_q),
        .ien_q  (ien_q),
        .irq    (irq_out)
    );

    AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_out && !wr_ien && ch_wrap == '0) |=> !irq_out); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq_out); // R1

endmodule

// File: tb/test_sixch_timer_unit.sv
`timescale 1ns/1ps
module test_sixch_timer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    sixch_timer_unit i_sixch_timer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    // behavioural reference model
    bit [31:0] m_ctrl [6];
    bit [31:0] m_rld  [6];
    bit [31:0] m_cnt  [6];
    bit        m_run  [6];
    bit [5:0]  m_cap, m_en;
    bit        m_dis, m_susp, m_rmode;

    function automatic int base_of(input int ch);
        return 'h10 + 'h20 * (ch / 2) + 4 * (ch % 2);
    endfunction

    function automatic bit [31:0] mread(input bit [7:0] a);
        bit [31:0] r;
        r = 0;
        if (a == 8'h00)      r = (32'(m_rmode) << 8) | (32'(m_susp) << 4) | 32'(m_dis);
        else if (a == 8'h08) r = 32'h0000_5900;
        else if (a == 8'hF4) r = 32'(m_en);
        else if (a == 8'hFC) r = 32'(m_cap);
        else begin
            for (int ch = 0; ch < 6; ch++) begin
                int b;
                b = base_of(ch);
                if (a == 8'(b))        r = m_ctrl[ch];
                if (a == 8'(b + 8))    r = 32'(m_run[ch]);
                if (a == 8'(b + 'h10)) r = m_rld[ch];
                if (a == 8'(b + 'h18)) r = m_cnt[ch];
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < 6; ch++) begin
                m_ctrl[ch] = 0; m_rld[ch] = 0; m_cnt[ch] = 0; m_run[ch] = 0;
            end
            m_cap = 0; m_en = 0; m_dis = 0; m_susp = 0; m_rmode = 0;
        end else begin
            bit [5:0] wrapv;
            bit [5:0] clr;
            wrapv = 0;
            for (int ch = 0; ch < 6; ch++) begin
                int  b;
                bit  wrun;
                b = base_of(ch);
                wrun = reg_wr && !m_dis && (reg_addr == 8'(b + 8));
                if (wrun) begin
                    if (reg_wdata[2]) m_cnt[ch] = m_rld[ch];
                    m_run[ch] = reg_wdata[0];
                end else if (m_run[ch] && !m_dis) begin
                    if (m_cnt[ch] == 0) begin
                        m_cnt[ch] = m_rld[ch];
                        wrapv[ch] = 1'b1;
                    end else begin
                        m_cnt[ch] = m_cnt[ch] - 1;
                    end
                end
                if (reg_wr && !m_dis && reg_addr == 8'(b))        m_ctrl[ch] = reg_wdata & 32'h5C4;
                if (reg_wr && !m_dis && reg_addr == 8'(b + 'h10)) m_rld[ch]  = reg_wdata;
            end
            clr = (reg_wr && reg_addr == 8'hFC) ? reg_wdata[5:0] : 6'd0;
            m_cap = (m_cap & ~clr) | wrapv;
            if (reg_wr && reg_addr == 8'hF4) m_en = reg_wdata[5:0];
            if (reg_wr && reg_addr == 8'h00) begin
                m_dis = reg_wdata[0]; m_susp = reg_wdata[4]; m_rmode = reg_wdata[8];
            end
        end
    end

    task automatic check(input string tag, input bit [31:0] got, input bit [31:0] exp, input string what);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // one bus cycle, compared against the model on that cycle
    task automatic cyc(input bit wr, input bit [7:0] a, input bit [31:0] d, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        #1;
        check(tag, reg_rdata, mread(a), $sformatf("rdata@%h", a));
        check(tag, 32'(irq_out), 32'((m_cap & m_en) != 0), "irq_out");
    endtask

    task automatic rd(input bit [7:0] a, input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d, input string tag);
        cyc(1'b1, a, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 1, "R1"); rd(8'hF4, 1, "R1"); rd(8'hFC, 1, "R1");
        rd(8'h10, 1, "R1"); rd(8'h28, 1, "R1"); rd(8'h6C, 1, "R1");
        // R2 identification
        rd(8'h08, 1, "R2"); wr(8'h08, 32'hFFFF_FFFF, "R2"); rd(8'h08, 2, "R2");
        // R4 control masking, channel 3 base 0x34
        wr(8'h34, 32'hFFFF_FFFF, "R4"); rd(8'h34, 1, "R4"); rd(8'h4C, 2, "R4");
        // R7 channel 0: reload 5, start with load
        wr(8'h20, 32'd5, "R7"); wr(8'h18, 32'h5, "R5"); rd(8'h28, 14, "R7");
        // R9 enable channel 0, watch irq, then clear
        wr(8'hF4, 32'h01, "R9"); rd(8'hFC, 3, "R9");
        wr(8'hFC, 32'h3F, "R8"); rd(8'hFC, 2, "R8"); rd(8'h28, 5, "R6");
        // R5 stop then restart without load
        wr(8'h18, 32'h0, "R5"); rd(8'h28, 4, "R5"); rd(8'h18, 1, "R5");
        wr(8'h18, 32'h1, "R5"); rd(8'h28, 4, "R5");
        // R6 count register writes ignored
        wr(8'h28, 32'h1234, "R6"); rd(8'h28, 2, "R6");
        // R7 reload of zero on channel 5 (base 0x54), set beats clear
        wr(8'hF4, 32'h20, "R9"); wr(8'h5C, 32'h1, "R7"); rd(8'h6C, 3, "R7");
        wr(8'hFC, 32'h20, "R8"); rd(8'hFC, 2, "R8");
        wr(8'h5C, 32'h0, "R5"); wr(8'hFC, 32'h20, "R8"); rd(8'hFC, 2, "R8");
        // R10 halt the core
        wr(8'h00, 32'h111, "R10"); rd(8'h28, 4, "R10");
        wr(8'h20, 32'd99, "R10"); rd(8'h20, 1, "R10");
        wr(8'h18, 32'h4, "R10"); rd(8'h18, 1, "R10");
        wr(8'hF4, 32'h3F, "R10"); rd(8'hF4, 1, "R10");
        wr(8'hFC, 32'h3F, "R10"); rd(8'hFC, 1, "R10");
        wr(8'h00, 32'h110, "R10"); rd(8'h28, 6, "R10"); rd(8'h00, 1, "R10");
        // R3 channel 2 (base 0x30) and unmapped reads
        wr(8'h40, 32'd3, "R3"); wr(8'h38, 32'h5, "R3"); rd(8'h48, 9, "R3");
        rd(8'h04, 1, "R3"); rd(8'h0C, 1, "R3"); rd(8'hF8, 1, "R3");
        rd(8'h70, 1, "R3"); rd(8'h12, 1, "R3");
        // R6 wide reload on channel 4 (base 0x50)
        wr(8'h60, 32'hFFFF_FFF0, "R6"); wr(8'h58, 32'h5, "R6"); rd(8'h68, 5, "R6");
        for (int ch = 0; ch < 6; ch++) begin
            rd(8'(base_of(ch) + 'h18), 1, "R3");
            rd(8'(base_of(ch) + 'h08), 1, "R3");
        end
        rd(8'hFC, 2, "R9");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule